// File: doc/BRIEF.md
# Shared GPIO Port Controller

This block is a 16-bit general-purpose I/O port. Each pin can be driven by the port's own registers or handed over to an attached peripheral. On the bus side there are write strobes for three registers: a direction register, a data latch and an analog-select register. There is also a read selector that returns the direction register, the data latch or the sampled pin level. On the pad side the block drives a per-pin output enable and output value, and it receives the per-pin input level.

A peripheral claims a pin by raising that pin's enable bit. While the enable bit is high, the peripheral's own output enable and output data drive the pad, and the port registers have no effect on that pin. The pad input always passes straight through to the peripheral. Pins marked analog read as zero on a pin read. To feed a converter, software must also set those pins to input.

A pin read returns pad levels that were registered one clock earlier. A read placed directly after a direction change or a latch write can therefore return the old pin state. Software must leave one cycle between the write and the read.

Top module: `shared_port_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes its reset state after that edge: direction register all ones (all pins are inputs), data latch zero, analog-select register all ones (all pins analog).
- R2: For a pin whose peripheral enable is 0, `pad_oe` is the inverse of its direction bit (direction 1 = input, so `pad_oe` = 0), and `pad_out` equals its data-latch bit.
- R3: For a pin whose peripheral enable is 1, `pad_oe` equals `per_oe` and `pad_out` equals `per_out` for that pin. The pin's direction bit and latch bit have no effect on it.
- R4: A pulse on either `wr_lat` or `wr_pin` loads `wr_data` into the single data latch at the next clock edge.
- R5: The read selector `rd_sel` uses these codes: 0 returns the direction register, 1 the data latch, 2 the sampled pin level. `rd_data` responds combinationally to `rd_sel`.
- R6: On a pin read (`rd_sel`=2), every bit whose analog-select bit is 1 reads as 0, whatever the pad level. A latch read is not affected by the analog selection.
- R7: `pad_in` passes through one sampling register. A pin read returns `pad_in` as it was at the previous clock edge. A read in the cycle right after a direction or latch write still shows the old pin state, and a read one cycle later shows the new state.
- R8: `per_in` equals `pad_in` on every bit, whatever the peripheral enables are.
- R9: `rd_sel`=3 returns all zeros.
- R10: A pulse on `wr_dir` or `wr_ana` loads `wr_data` into that register at the next clock edge. A register with no write strobe keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_dir | input | 1 | Write strobe, direction register |
| wr_lat | input | 1 | Write strobe, data latch (latch address) |
| wr_pin | input | 1 | Write strobe, data latch (port address) |
| wr_ana | input | 1 | Write strobe, analog-select register |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source: 0 dir, 1 latch, 2 pins, 3 none |
| rd_data | output | 16 | Read data |
| pad_oe | output | 16 | Per-pin pad output enable |
| pad_out | output | 16 | Per-pin pad output value |
| pad_in | input | 16 | Per-pin pad input level |
| per_en | input | 16 | Per-pin peripheral ownership |
| per_oe | input | 16 | Peripheral output enable |
| per_out | input | 16 | Peripheral output data |
| per_in | output | 16 | Pad input forwarded to the peripheral |

## Verification
A corrupted direction or latch bit appears on `pad_oe` or `pad_out` in the same cycle as the fault, because those outputs are combinational from the registers. It also appears on a register read at once. A bad sampling register or a bad analog mask shows only on a pin read. The bench loops `pad_out` back through `pad_in` under `pad_oe`, so a sampler that is one cycle early or one cycle late is caught by reading the pins in each of the two cycles after a write. A peripheral bit that routes to the wrong pin shows on the pad outputs immediately.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port controller.
// Assumes: the read selector is two bits wide.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        RD_DIR  = 2'd0,
        RD_LAT  = 2'd1,
        RD_PIN  = 2'd2,
        RD_NONE = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/port_cfg_regs.sv
// Port configuration registers: direction, data latch, analog select.
// Assumes: write strobes are single-cycle and sampled at posedge clk;
// both latch strobes carry the same data word.
module port_cfg_regs #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_lat,
    input  logic             wr_pin,
    input  logic             wr_ana,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] ana_q
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // Direction register: ones mean input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= ALL_ONES;
        else if (wr_dir) dir_q <= wr_data;
    end

    // Data latch, loaded from either of the two latch-write addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                dir_lat_reset();
        else if (wr_lat || wr_pin) lat_q <= wr_data;
    end

    // Analog-select register: ones mean analog.
    always_ff @(posedge clk) begin
        if (!rst_n)      ana_q <= ALL_ONES;
        else if (wr_ana) ana_q <= wr_data;
    end

    task automatic dir_lat_reset();
        lat_q <= '0;
    endtask

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dir_q == ALL_ONES && lat_q == '0 && ana_q == ALL_ONES));
    a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (wr_lat || wr_pin)) |=> lat_q == $past(wr_data));
    a_r10_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_dir) |=> dir_q == $past(wr_data));
    a_r10_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_dir) |=> $stable(dir_q));
    a_r10_ana_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_ana) |=> ana_q == $past(wr_data));
endmodule

// File: rtl/port_pin_mux.sv
// Per-pin output multiplexers: peripheral or port registers drive the pad.
// Assumes: direction bit 1 = input, so the port output enable is its inverse.
module port_pin_mux #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] per_en,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Select the owner of pin i.
        always_comb begin
            if (per_en[i]) begin
                pad_oe[i]  = per_oe[i];
                pad_out[i] = per_out[i];
            end else begin
                pad_oe[i]  = ~dir_q[i];
                pad_out[i] = lat_q[i];
            end
        end
    end
endmodule

// File: rtl/port_in_sample.sv
// One-stage sampling register on the pad inputs, giving the one-cycle
// read latency. Assumes pad_in is already synchronous to clk.
module port_in_sample #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_q
);
    // Capture the pad levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pad_in;
    end

    a_r7_one_cycle_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pin_q == $past(pad_in));
endmodule

// File: rtl/shared_port_ctrl.sv
// Shared GPIO port top: registers, pin multiplexers, input sampler, read mux.
// Assumes: single clock domain, synchronous active-low reset.
module shared_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_lat,
    input  logic             wr_pin,
    input  logic             wr_ana,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] per_en,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] per_in
);
    logic [WIDTH-1:0] dir_q, lat_q, ana_q, pin_q;
    rd_sel_e          sel;

    port_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_dir), .wr_lat(wr_lat), .wr_pin(wr_pin), .wr_ana(wr_ana),
        .wr_data(wr_data),
        .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q)
    );

    port_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .per_en(per_en), .per_oe(per_oe), .per_out(per_out),
        .dir_q(dir_q), .lat_q(lat_q),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    port_in_sample #(.WIDTH(WIDTH)) u_sample (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_q(pin_q)
    );

    // The peripheral always sees the raw pad input.
    assign per_in = pad_in;

    // Read multiplexer; analog pins are masked to zero on a pin read.
    always_comb begin
        sel = rd_sel_e'(rd_sel);
        unique case (sel)
            RD_DIR:  rd_data = dir_q;
            RD_LAT:  rd_data = lat_q;
            RD_PIN:  rd_data = pin_q & ~ana_q;
            default: rd_data = '0;
        endcase
    end

    a_r6_analog_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |-> (rd_data & ana_q) == '0);
    a_r9_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> rd_data == '0);
    a_r3_per_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ per_oe) & per_en) == '0);
    a_r2_idle_pins_not_per: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ lat_q) & ~per_en) == '0);
endmodule

// File: tb/shared_port_ctrl_test.sv
`timescale 1ns/100ps
module shared_port_ctrl_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_dir = 0, wr_lat = 0, wr_pin = 0, wr_ana = 0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data, pad_oe, pad_out, pad_in, per_in;
    logic [W-1:0] per_en = '0, per_oe = '0, per_out = '0;
    logic [W-1:0] ext = 16'hA5C3;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 rd_data, 1 pad_oe, 2 pad_out, 3 per_in
        logic [W-1:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    // Pad model: driven pins loop back, others see the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    shared_port_ctrl #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_dir), .wr_lat(wr_lat), .wr_pin(wr_pin), .wr_ana(wr_ana),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in),
        .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .per_in(per_in)
    );

    // Monitor: compare every queued expectation one time unit after the negedge.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rd_data;
                1: act = pad_oe;
                2: act = pad_out;
                default: act = per_in;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [W-1:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Read check in the current cycle, then advance one cycle.
    task automatic rd_chk(input logic [1:0] sel, input logic [W-1:0] exp, input string tag);
        rd_sel = sel;
        push(0, exp, tag);
        @(negedge clk);
    endtask

    // One-cycle write strobe; returns at the next negedge with strobes low.
    task automatic wr(input int which, input logic [W-1:0] d);
        wr_data = d;
        wr_dir = (which == 0); wr_lat = (which == 1);
        wr_pin = (which == 2); wr_ana = (which == 3);
        @(negedge clk);
        wr_dir = 0; wr_lat = 0; wr_pin = 0; wr_ana = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] eoe, eout;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        push(1, 16'h0000, "R1 pad_oe");
        rd_chk(2'd0, 16'hFFFF, "R1 dir");
        rd_chk(2'd1, 16'h0000, "R1 latch");
        rd_chk(2'd2, 16'h0000, "R1 pins analog");
        // R10 analog off: pins now visible
        wr(3, 16'h0000);
        rd_chk(2'd2, 16'hA5C3, "R10 ana write");
        // R2/R4/R5/R7 low byte outputs, latch write
        wr(0, 16'hFF00);
        wr(1, 16'h1234);
        rd_chk(2'd2, 16'hA500, "R7 old pins after latch write");
        rd_chk(2'd2, 16'hA534, "R7 new pins");
        push(1, 16'h00FF, "R2 pad_oe");
        push(2, 16'h1234, "R2 pad_out");
        rd_chk(2'd1, 16'h1234, "R4 wr_lat");
        rd_chk(2'd0, 16'hFF00, "R5 dir read");
        // R4 port-address write
        wr(2, 16'h00F0);
        rd_chk(2'd2, 16'hA534, "R7 old pins after port write");
        rd_chk(2'd2, 16'hA5F0, "R7 new pins after port write");
        rd_chk(2'd1, 16'h00F0, "R4 wr_pin");
        // R6 analog mask
        wr(3, 16'h0F0F);
        rd_chk(2'd2, 16'hA0F0, "R6 analog masked");
        rd_chk(2'd1, 16'h00F0, "R6 latch unaffected");
        // R3 peripheral override, R8 forward
        per_en = 16'h0103; per_oe = 16'h0101; per_out = 16'h0103;
        eoe  = (16'h00FF & ~per_en) | (per_oe & per_en);
        eout = (16'h00F0 & ~per_en) | (per_out & per_en);
        push(1, eoe, "R3 pad_oe");
        push(2, eout, "R3 pad_out");
        push(3, (eoe & eout) | (~eoe & ext), "R8 per_in enabled");
        rd_chk(2'd3, 16'h0000, "R9 unused select");
        per_en = '0;
        ext = 16'h5A3C;
        push(3, (16'h00FF & 16'h00F0) | (16'hFF00 & 16'h5A3C), "R8 per_in disabled");
        @(negedge clk);
        ext = 16'hA5C3;
        // R7 direction change latency
        wr(3, 16'h0000);
        @(negedge clk);
        wr(0, 16'hFFFF);
        rd_chk(2'd2, 16'hA5F0, "R7 old pins after dir write");
        rd_chk(2'd2, 16'hA5C3, "R7 new pins after dir write");
        push(1, 16'h0000, "R2 all inputs");
        @(negedge clk);
        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(2'd0, 16'hFFFF, "R1 dir after reset");
        rd_chk(2'd1, 16'h0000, "R1 latch after reset");
        rd_chk(2'd2, 16'h0000, "R1 analog after reset");
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule